// File: doc/BRIEF.md
# Limit-Checked Windowed Memory Port

This block gives a host two independent windows into on-chip SRAM. Each window has a base address, a pair of access limits and a byte offset. The host reaches memory indirectly. It first sets the offset. It then reads or writes a data register. Every data access moves the offset forward by the access size, so back-to-back data accesses walk through the window without the host rewriting the offset.

Before a memory cycle is issued, the offset is compared with the limit that applies to the access direction. The read limit and the write limit are independent. This lets a window be disabled, read-only, write-only, or split into a read/write lower zone with a read-only or write-only upper zone above it. An access that fails the check produces no SRAM cycle. A refused read returns all ones and a refused write is discarded. The SRAM side is a single request port: read data is expected one cycle after the request.

A five-state controller sequences each host command. IDLE accepts a request and latches it. CHECK reads a register, or evaluates the limit for a data access. MEM drives the SRAM request for one cycle. DATA captures read data. DONE acknowledges the host and commits register writes and the offset step. The transitions are:
- IDLE→CHECK when the host requests.
- CHECK→MEM when a data access is permitted, otherwise CHECK→DONE.
- MEM→DONE for a write, MEM→DATA for a read.
- DATA→DONE.
- DONE→IDLE.

Top module: `sramwin_port`

## Requirements
- R1: After reset every base, limits and offset register reads as zero, `hst_ack` and `mem_req` are low, and a data access is refused because both limits are zero.
- R2: A request is accepted only in IDLE, and each accepted request yields exactly one single-cycle `hst_ack`. A request raised while a command is in flight is ignored and changes no register.
- R3: Register select `hst_sel` encodes 0 = base, 1 = limits, 2 = offset, 3 = data, and `hst_win` picks the window. Base bits [1:0] read as zero. The limits word holds the read limit in [15:0] and the write limit in [31:16]. The offset keeps bits [14:0], and its upper bits read as zero.
- R4: A read is permitted only when offset[14:2] is below read_limit[15:2]. A write is permitted only when offset[14:2] is below write_limit[31:18]. Limit bits [1:0] of each field are ignored.
- R5: A refused data read returns 0xFFFFFFFF and a refused data write is dropped; neither raises `mem_req`.
- R6: `hst_size` encodes 0 = byte, 1 = halfword, 2 = word (3 acts as word). The byte lane is offset[1:0] for a byte and {offset[1],0} for a halfword. `mem_be` is 0x1, 0x3 or 0xF shifted to that lane, and `mem_wdata` is the size-masked host data shifted to the same lane.
- R7: Every data access, permitted or refused, adds 1, 2 or 4 (by size) to the window's offset, wrapping modulo 2^15.
- R8: `mem_addr` equals the base (bits [1:0] zero) plus offset with bits [1:0] cleared.
- R9: Read data is sampled from `mem_rdata` in the cycle after `mem_req`, shifted down from its lane, masked to the access size and zero-extended onto `hst_rdata`.
- R10: Writing zero to a limits register disables that window's data accesses from the next command on. The two windows' registers are fully independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_req | input | 1 | Host command strobe |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_win | input | WIN_W | Window select |
| hst_sel | input | 2 | Register select |
| hst_size | input | 2 | Data access size |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Command complete pulse |
| hst_rdata | output | 32 | Read result, valid with `hst_ack` |
| mem_req | output | 1 | SRAM cycle request |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM byte address, word aligned |
| mem_be | output | 4 | SRAM byte enables |
| mem_wdata | output | 32 | SRAM write data, lane aligned |
| mem_rdata | input | 32 | SRAM read data, one cycle after request |

## Verification
A new host request can arrive while a permitted read is still in its MEM or DATA state. The SRAM response and the host strobe then fall in the same cycle. The bench provokes this by raising an offset-register write in the MEM cycle of a window-1 read. It judges the result by requiring exactly one acknowledge carrying the SRAM data, and by reading the offset back afterwards: it must show the auto-increment of the read and not the ignored write. A second overlap is a permitted access whose auto-increment lands the offset on a limit edge. The following access must then be refused, which the bench confirms through the all-ones read data and the absence of any SRAM cycle.

// File: rtl/sramwin_pkg.sv
package sramwin_pkg;
    localparam int LIM_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_t;

    typedef enum logic [1:0] {
        RG_BASE   = 2'd0,
        RG_LIMITS = 2'd1,
        RG_OFFSET = 2'd2,
        RG_DATA   = 2'd3
    } reg_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MEM,
        ST_DATA,
        ST_DONE
    } fsm_state_t;

    function automatic logic [2:0] size_bytes(input xfer_size_t s);
        unique case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/sramwin_regs.sv
module sramwin_regs
    import sramwin_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_lim,
    input  logic              wr_off,
    input  logic [31:0]       wdata,
    input  logic              step_en,
    input  logic [2:0]        step_bytes,
    output logic [ADDR_W-1:0] base_q,
    output logic [31:0]       lim_q,
    output logic [OFF_W-1:0]  off_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            lim_q  <= '0;
            off_q  <= '0;
        end else begin
            if (wr_base) base_q <= {wdata[ADDR_W-1:2], 2'b00};
            if (wr_lim)  lim_q  <= wdata;
            if (wr_off)       off_q <= wdata[OFF_W-1:0];
            else if (step_en) off_q <= off_q + OFF_W'(step_bytes);
        end
    end

    // R7: the offset advances by the access size, modulo the offset width
    a_r7_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !wr_off |=> off_q == $past(off_q) + OFF_W'($past(step_bytes)));
endmodule

// File: rtl/sramwin_gate.sv
module sramwin_gate
    import sramwin_pkg::*;
#(
    parameter int OFF_W = 15
) (
    input  logic [OFF_W-1:0] off,
    input  logic [31:0]      lim,
    input  logic             we,
    output logic             ok
);
    localparam int LW = LIM_W - 2;

    logic [LW-1:0] word_idx;
    logic [LW-1:0] rd_words;
    logic [LW-1:0] wr_words;
    logic          unused_lim_bits;

    assign word_idx = LW'(off[OFF_W-1:2]);
    assign rd_words = lim[LIM_W-1:2];
    assign wr_words = lim[2*LIM_W-1:LIM_W+2];
    assign ok       = we ? (word_idx < wr_words) : (word_idx < rd_words);
    assign unused_lim_bits = ^{lim[1:0], lim[LIM_W+1:LIM_W]};
endmodule

// File: rtl/sramwin_lane.sv
module sramwin_lane
    import sramwin_pkg::*;
(
    input  xfer_size_t  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    input  logic [31:0] rdata_raw,
    output logic [3:0]  be,
    output logic [31:0] wdata_lane,
    output logic [31:0] rdata_just
);
    logic [1:0]  lane_eff;
    logic [31:0] mask;
    logic [3:0]  be_base;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin lane_eff = lane;          mask = 32'h0000_00FF; be_base = 4'b0001; end
            SZ_HALF: begin lane_eff = {lane[1], 1'b0}; mask = 32'h0000_FFFF; be_base = 4'b0011; end
            default: begin lane_eff = 2'b00;         mask = 32'hFFFF_FFFF; be_base = 4'b1111; end
        endcase
    end

    assign be         = be_base << lane_eff;
    assign wdata_lane = (wdata & mask) << {lane_eff, 3'b000};
    assign rdata_just = (rdata_raw >> {lane_eff, 3'b000}) & mask;
endmodule

// File: rtl/sramwin_port.sv
module sramwin_port
    import sramwin_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 15,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [WIN_W-1:0]  hst_win,
    input  logic [1:0]        hst_sel,
    input  logic [1:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic              hst_ack,
    output logic [31:0]       hst_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    fsm_state_t state, state_nx;

    logic             cmd_we;
    logic [WIN_W-1:0] cmd_win;
    reg_sel_t         cmd_sel;
    xfer_size_t       cmd_size;
    logic [31:0]      cmd_wdata;
    logic [31:0]      result_q;

    logic [ADDR_W-1:0] base_arr [NUM_WIN];
    logic [31:0]       lim_arr  [NUM_WIN];
    logic [OFF_W-1:0]  off_arr  [NUM_WIN];

    logic [ADDR_W-1:0] base_sel;
    logic [31:0]       lim_sel;
    logic [OFF_W-1:0]  off_sel;
    logic              gate_ok;
    logic [31:0]       rd_just;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hst_req) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (cmd_sel == RG_DATA && gate_ok) ? ST_MEM : ST_DONE;
            ST_MEM:   state_nx = cmd_we ? ST_DONE : ST_DATA;
            ST_DATA:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        hst_ack = 1'b0;
        mem_req = 1'b0;
        unique case (state)
            ST_MEM:  mem_req = 1'b1;
            ST_DONE: hst_ack = 1'b1;
            default: ;
        endcase
    end

    assign hst_rdata = result_q;
    assign mem_we    = cmd_we;
    assign mem_addr  = base_sel + ADDR_W'({off_sel[OFF_W-1:2], 2'b00});

    // ---------------- command latch ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_we    <= 1'b0;
            cmd_win   <= '0;
            cmd_sel   <= RG_BASE;
            cmd_size  <= SZ_BYTE;
            cmd_wdata <= '0;
        end else if (state == ST_IDLE && hst_req) begin
            cmd_we    <= hst_we;
            cmd_win   <= hst_win;
            cmd_sel   <= reg_sel_t'(hst_sel);
            cmd_size  <= xfer_size_t'(hst_size);
            cmd_wdata <= hst_wdata;
        end
    end

    // ---------------- window registers ----------------
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic hit;
        assign hit = (state == ST_DONE) && (cmd_win == WIN_W'(i));
        sramwin_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_base    (hit && cmd_we && cmd_sel == RG_BASE),
            .wr_lim     (hit && cmd_we && cmd_sel == RG_LIMITS),
            .wr_off     (hit && cmd_we && cmd_sel == RG_OFFSET),
            .wdata      (cmd_wdata),
            .step_en    (hit && cmd_sel == RG_DATA),
            .step_bytes (size_bytes(cmd_size)),
            .base_q     (base_arr[i]),
            .lim_q      (lim_arr[i]),
            .off_q      (off_arr[i])
        );
    end

    assign base_sel = base_arr[cmd_win];
    assign lim_sel  = lim_arr[cmd_win];
    assign off_sel  = off_arr[cmd_win];

    sramwin_gate #(.OFF_W(OFF_W)) u_gate (
        .off (off_sel),
        .lim (lim_sel),
        .we  (cmd_we),
        .ok  (gate_ok)
    );

    sramwin_lane u_lane (
        .size       (cmd_size),
        .lane       (off_sel[1:0]),
        .wdata      (cmd_wdata),
        .rdata_raw  (mem_rdata),
        .be         (mem_be),
        .wdata_lane (mem_wdata),
        .rdata_just (rd_just)
    );

    // ---------------- result register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (state == ST_CHECK) begin
            if (cmd_we) begin
                result_q <= '0;
            end else begin
                unique case (cmd_sel)
                    RG_BASE:   result_q <= 32'(base_sel);
                    RG_LIMITS: result_q <= lim_sel;
                    RG_OFFSET: result_q <= 32'(off_sel);
                    default:   result_q <= gate_ok ? result_q : 32'hFFFF_FFFF;
                endcase
            end
        end else if (state == ST_DATA) begin
            result_q <= rd_just;
        end
    end

    // ---------------- assertions ----------------
    // R2: acknowledge is a single-cycle pulse
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack);
    // R2: a command in flight is not overwritten by a new request
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cmd_wdata) && $stable(cmd_sel) && $stable(cmd_win));
    // R4: a direction whose limit is zero never reaches the SRAM
    a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_we ? (lim_sel[31:18] != '0) : (lim_sel[15:2] != '0)));
    // R5: only data-register commands produce SRAM cycles
    a_r5_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cmd_sel == RG_DATA);
    // R6: byte enables form a legal lane pattern
    a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));
    // R8: SRAM addresses are word aligned
    a_r8_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

// File: tb/sim_sramwin_port.sv
module sim_sramwin_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0, hst_we = 1'b0;
    logic [0:0]  hst_win = '0;
    logic [1:0]  hst_sel = '0, hst_size = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ack, mem_req, mem_we;
    logic [31:0] hst_rdata, mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    int tests = 0, fails = 0, acks = 0;
    bit done = 0;

    logic [31:0] q_ack[$];
    string       q_atag[$];
    logic [31:0] q_maddr[$];
    logic [31:0] q_mwd[$];
    logic [3:0]  q_mbe[$];
    bit          q_mwe[$];
    string       q_mtag[$];

    logic [31:0] ram [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sramwin_port u0 (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
        .hst_win(hst_win), .hst_sel(hst_sel), .hst_size(hst_size),
        .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // single-cycle SRAM model
    always @(posedge clk) begin
        if (mem_req) begin
            for (int b = 0; b < 4; b++)
                if (mem_we && mem_be[b]) ram[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            mem_rdata <= ram[mem_addr[7:2]];
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && hst_ack) begin
            acks++;
            tests++;
            if (q_ack.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected ack: rdata=%h expected no ack", hst_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = q_ack.pop_front();
                t = q_atag.pop_front();
                if (hst_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: rdata=%h expected %h", t, hst_rdata, e);
                end
            end
        end
        if (rst_n && mem_req) begin
            tests++;
            if (q_maddr.size() == 0) begin
                fails++;
                $display("FAIL R5 unexpected SRAM cycle: addr=%h we=%0d expected none", mem_addr, mem_we);
            end else begin
                logic [31:0] ea, ew;
                logic [3:0]  eb;
                bit          ewe;
                string       t;
                ea = q_maddr.pop_front(); ew = q_mwd.pop_front();
                eb = q_mbe.pop_front();   ewe = q_mwe.pop_front();
                t = q_mtag.pop_front();
                if (mem_addr !== ea || mem_be !== eb || mem_we !== ewe || (ewe && mem_wdata !== ew)) begin
                    fails++;
                    $display("FAIL %s: addr=%h be=%h we=%0d wd=%h expected addr=%h be=%h we=%0d wd=%h",
                             t, mem_addr, mem_be, mem_we, mem_wdata, ea, eb, ewe, ew);
                end
            end
        end
    end

    task automatic mexp(input logic [31:0] a, input bit we, input logic [3:0] be,
                        input logic [31:0] wd, input string t);
        q_maddr.push_back(a); q_mwe.push_back(we); q_mbe.push_back(be);
        q_mwd.push_back(wd); q_mtag.push_back(t);
    endtask

    task automatic op(input int win, input int sel, input bit we, input int size,
                      input logic [31:0] wd, input logic [31:0] exp, input string t);
        int tgt;
        tgt = acks + 1;
        q_ack.push_back(exp); q_atag.push_back(t);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_win = 1'(win);
        hst_sel = 2'(sel); hst_size = 2'(size); hst_wdata = wd;
        @(negedge clk);
        hst_req = 1'b0;
        while (acks < tgt) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ram[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (hst_ack !== 1'b0 || mem_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle outputs: ack=%0d req=%0d expected 0 0", hst_ack, mem_req);
        end
        // R1 reset state
        op(0, 0, 0, 2, 0, 32'h0, "R1 win0 base");
        op(0, 1, 0, 2, 0, 32'h0, "R1 win0 limits");
        op(0, 2, 0, 2, 0, 32'h0, "R1 win0 offset");
        op(1, 1, 0, 2, 0, 32'h0, "R1 win1 limits");
        op(0, 3, 0, 2, 0, 32'hFFFF_FFFF, "R1 disabled read");
        op(0, 2, 0, 2, 0, 32'h4, "R7 refused access steps offset");
        // R3 configuration of window 0: write limit 0x10, read limit 0x20
        op(0, 0, 1, 2, 32'h0000_0043, 0, "R3 base write");
        op(0, 0, 0, 2, 0, 32'h0000_0040, "R3 base low bits zero");
        op(0, 1, 1, 2, 32'h0010_0020, 0, "R3 limits write");
        op(0, 1, 0, 2, 0, 32'h0010_0020, "R3 limits readback");
        op(0, 2, 1, 2, 32'h0, 0, "R3 offset write");
        // R8 word writes in the read/write zone
        mexp(32'h40, 1, 4'hF, 32'h1122_3344, "R8 word write 0");
        op(0, 3, 1, 2, 32'h1122_3344, 0, "R8 word write 0 ack");
        mexp(32'h44, 1, 4'hF, 32'h5566_7788, "R8 word write 1");
        op(0, 3, 1, 2, 32'h5566_7788, 0, "R8 word write 1 ack");
        mexp(32'h48, 1, 4'hF, 32'h99AA_BBCC, "R8 word write 2");
        op(0, 3, 1, 2, 32'h99AA_BBCC, 0, "R8 word write 2 ack");
        mexp(32'h4C, 1, 4'hF, 32'hDDEE_FF00, "R8 word write 3");
        op(0, 3, 1, 2, 32'hDDEE_FF00, 0, "R8 word write 3 ack");
        // R4 offset now 0x10 == write limit: refused (read-only zone)
        op(0, 3, 1, 2, 32'hDEAD_0000, 0, "R4 write at write limit dropped");
        op(0, 2, 0, 2, 0, 32'h14, "R7 offset after five word accesses");
        // R9 word and sub-word reads
        op(0, 2, 1, 2, 32'h0, 0, "R3 offset rewind");
        mexp(32'h40, 0, 4'hF, 0, "R9 word read");
        op(0, 3, 0, 2, 0, 32'h1122_3344, "R9 word read data");
        op(0, 2, 1, 2, 32'h1, 0, "R3 offset to 1");
        mexp(32'h40, 0, 4'h2, 0, "R6 byte lane 1");
        op(0, 3, 0, 0, 0, 32'h33, "R6 byte read lane 1");
        mexp(32'h40, 0, 4'hC, 0, "R6 half upper lanes");
        op(0, 3, 0, 1, 0, 32'h1122, "R6 half read at offset 2");
        op(0, 2, 0, 2, 0, 32'h4, "R7 offset after byte and half");
        op(0, 2, 1, 2, 32'h5, 0, "R3 offset to 5");
        mexp(32'h44, 1, 4'h2, 32'h0000_AB00, "R6 byte write lane 1");
        op(0, 3, 1, 0, 32'hFFFF_FFAB, 0, "R6 byte write ack");
        op(0, 2, 1, 2, 32'h4, 0, "R3 offset to 4");
        mexp(32'h44, 0, 4'hF, 0, "R6 merged word read");
        op(0, 3, 0, 2, 0, 32'h5566_AB88, "R6 byte merge visible");
        // R4 read-only upper zone and read limit edge
        op(0, 2, 1, 2, 32'h1C, 0, "R3 offset to 0x1C");
        mexp(32'h5C, 0, 4'hF, 0, "R4 last readable word");
        op(0, 3, 0, 2, 0, 32'h0, "R4 last readable word data");
        op(0, 3, 0, 2, 0, 32'hFFFF_FFFF, "R5 read at read limit refused");
        op(0, 2, 1, 2, 32'h18, 0, "R3 offset to 0x18");
        op(0, 3, 1, 2, 32'h1234_5678, 0, "R4 write in read-only zone dropped");
        // window 1 write-only
        op(1, 0, 1, 2, 32'h80, 0, "R10 win1 base");
        op(1, 1, 1, 2, 32'h0008_0000, 0, "R10 win1 write-only limits");
        mexp(32'h80, 1, 4'hF, 32'hCAFE_F00D, "R4 write-only write");
        op(1, 3, 1, 2, 32'hCAFE_F00D, 0, "R4 write-only write ack");
        op(1, 2, 1, 2, 32'h0, 0, "R3 win1 offset rewind");
        op(1, 3, 0, 2, 0, 32'hFFFF_FFFF, "R4 write-only read refused");
        op(0, 2, 0, 2, 0, 32'h1C, "R10 win0 offset independent");
        // window 1 split: read limit 4, write limit 8
        op(1, 1, 1, 2, 32'h0008_0004, 0, "R10 win1 split limits");
        op(1, 2, 1, 2, 32'h4, 0, "R3 win1 offset to 4");
        op(1, 3, 0, 2, 0, 32'hFFFF_FFFF, "R4 read in write-only zone refused");
        op(1, 2, 1, 2, 32'h4, 0, "R3 win1 offset to 4 again");
        mexp(32'h84, 1, 4'hF, 32'h0BAD_BEEF, "R4 write in write-only zone");
        op(1, 3, 1, 2, 32'h0BAD_BEEF, 0, "R4 write-only zone ack");
        // R10 limits to zero disables window 0
        op(0, 1, 1, 2, 32'h0, 0, "R10 win0 limits zero");
        op(0, 2, 1, 2, 32'h0, 0, "R3 win0 offset rewind");
        op(0, 3, 0, 2, 0, 32'hFFFF_FFFF, "R10 disabled window read refused");
        // R7 wrap and R3 upper offset bits
        op(1, 2, 1, 2, 32'h0000_FFFF, 0, "R3 offset upper bits");
        op(1, 2, 0, 2, 0, 32'h7FFF, "R3 offset keeps 15 bits");
        op(1, 3, 0, 0, 0, 32'hFFFF_FFFF, "R7 refused byte at top");
        op(1, 2, 0, 2, 0, 32'h0, "R7 offset wraps to zero");
        // R2 request during an in-flight read is ignored
        begin
            int tgt;
            tgt = acks + 1;
            q_ack.push_back(32'hCAFE_F00D); q_atag.push_back("R2 busy read data");
            mexp(32'h80, 0, 4'hF, 0, "R2 busy read");
            @(negedge clk);
            hst_req = 1'b1; hst_we = 1'b0; hst_win = 1'b1; hst_sel = 2'd3; hst_size = 2'd2;
            @(negedge clk);
            hst_req = 1'b0;
            @(negedge clk);
            hst_req = 1'b1; hst_we = 1'b1; hst_sel = 2'd2; hst_wdata = 32'h20;
            @(negedge clk);
            hst_req = 1'b0;
            while (acks < tgt) @(negedge clk);
        end
        op(1, 2, 0, 2, 0, 32'h4, "R2 ignored offset write");
        repeat (4) @(negedge clk);
        tests++;
        if (q_ack.size() != 0 || q_maddr.size() != 0) begin
            fails++;
            $display("FAIL R5 pending items: acks=%0d mem=%0d expected 0 0", q_ack.size(), q_maddr.size());
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule